// File: doc/BRIEF.md
# Ethernet UDP Receive Header Stripper and Frame Router

This block sits behind a MAC receive interface that carries both command traffic and transmit-side streaming traffic over a single port. It takes in one byte per cycle with a valid strobe and an end-of-frame marker. It removes the fixed combined link, network and transport header and decides from the total byte count of each frame where the remaining payload goes. A frame of the command length produces one parallel command word. A frame of the streaming length produces a burst of payload bytes on a ready/valid byte stream. A frame of any other length produces nothing and sets a sticky error flag. The header length and both frame lengths are parameters, so a new packet layout needs no logic change. The defaults are a 42-byte header, 49-byte command frames with 7 payload bytes, and 557-byte streaming frames with 515 payload bytes.

Payload bytes are written speculatively into a commit/rollback FIFO while the frame arrives. At end of frame the controller either commits the bytes, which makes them visible to the stream reader, or rolls back the write pointer, which discards them. A shift register captures the trailing payload bytes for the command word at the same time. When a frame starts, the controller checks whether the FIFO has room for a full streaming payload. If it does not, a streaming frame of that length is dropped whole and a sticky overflow flag is set.

The controller has three states. ST_IDLE waits for the first byte of a frame. ST_HDR counts header bytes. ST_PAY receives payload and makes the routing decision. Transitions:
- ST_IDLE to ST_HDR on the first byte, or to ST_PAY when the header is a single byte.
- ST_IDLE to ST_IDLE on a one-byte frame, which is a length error.
- ST_HDR to ST_PAY on the last header byte.
- ST_HDR to ST_IDLE when the frame ends inside the header, which is a length error.
- ST_PAY to ST_IDLE on the end-of-frame byte, with one of four outcomes: commit, command fire, overflow drop or length error.

Top module: `udp_rx_sorter`

## Requirements
- R1: The first HDR_LEN bytes of every frame never appear on either output. Payload byte k of a frame (the byte at frame index HDR_LEN+k) is the k-th byte delivered.
- R2: A frame of exactly CMD_LEN bytes raises cmd_valid for exactly one cycle, in the cycle after the end-of-frame byte is accepted. cmd_word holds the payload with the first payload byte in bits [CMD_W-1 -: 8] and the last payload byte in bits [7:0].
- R3: A frame of exactly STRM_LEN bytes delivers its STRM_LEN-HDR_LEN payload bytes in order on strm_data, with strm_last high only on the final byte. None of these bytes is presented before the frame's end-of-frame byte is accepted.
- R4: While strm_valid is high and strm_ready is low, strm_valid stays high and strm_data and strm_last hold their values.
- R5: A frame whose length is neither CMD_LEN nor STRM_LEN, including one that ends inside the header, produces no command and no stream byte, and sets len_err. len_err stays high until reset.
- R6: A streaming frame whose first byte arrives while the FIFO has fewer than STRM_LEN-HDR_LEN free entries is dropped entirely and sets ovf_err, which stays high until reset. Command frames are delivered regardless of FIFO space.
- R7: After reset, cmd_valid, strm_valid, len_err and ovf_err are all low.
- R8: A command frame emits nothing on the stream output.
- R9: Cycles with in_valid low inside a frame are not counted and do not alter the payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive byte strobe |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | Marks the final byte of a frame |
| cmd_valid | output | 1 | One-cycle pulse: cmd_word holds a new command |
| cmd_word | output | 8*(CMD_LEN-HDR_LEN) | Command payload, first byte in the top bits |
| strm_valid | output | 1 | Streaming byte available |
| strm_ready | input | 1 | Downstream accepts the streaming byte |
| strm_data | output | 8 | Streaming payload byte |
| strm_last | output | 1 | Final byte of a streaming payload |
| len_err | output | 1 | Sticky: a frame of unknown length was seen |
| ovf_err | output | 1 | Sticky: a streaming frame was dropped for lack of space |

## Verification
The bench builds the block with a 6-byte header, 9-byte command frames (3 payload bytes), 14-byte streaming frames (8 payload bytes) and a 16-entry FIFO. With these values two stalled streaming frames fill the FIFO exactly, so the third frame reaches the overflow drop within a few dozen cycles. Byte order, the end marker and the command word layout stay easy to predict at these sizes. The short header also puts a frame that ends inside the header, and frames that fall between or beyond the two valid lengths, within a short directed sequence.

// File: rtl/udp_sort_pkg.sv
package udp_sort_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } strm_entry_t;

endpackage

// File: rtl/udp_sort_ctrl.sv
module udp_sort_ctrl
    import udp_sort_pkg::*;
#(
    parameter int HDR_LEN  = 42,
    parameter int CMD_LEN  = 49,
    parameter int STRM_LEN = 557
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic room,
    output logic wr_en,
    output logic wr_last,
    output logic commit,
    output logic rollback,
    output logic cmd_shift,
    output logic cmd_fire,
    output logic len_err_set,
    output logic ovf_set
);
    localparam int MAXLEN = (STRM_LEN > CMD_LEN) ? STRM_LEN : CMD_LEN;
    localparam int CW     = $clog2(MAXLEN + 2);
    localparam logic [CW-1:0] HDR_LAST  = CW'(HDR_LEN - 1);
    localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_LEN - 1);
    localparam logic [CW-1:0] STRM_LAST = CW'(STRM_LEN - 1);
    localparam logic [CW-1:0] STRM_END  = CW'(STRM_LEN);

    rx_state_e      state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;
    logic           no_room, no_room_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            no_room <= 1'b0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            no_room <= no_room_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        state_nx    = state;
        cnt_nx      = cnt;
        no_room_nx  = no_room;
        wr_en       = 1'b0;
        wr_last     = 1'b0;
        commit      = 1'b0;
        rollback    = 1'b0;
        cmd_shift   = 1'b0;
        cmd_fire    = 1'b0;
        len_err_set = 1'b0;
        ovf_set     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    no_room_nx = !room;
                    if (in_last) begin
                        len_err_set = 1'b1;
                        cnt_nx      = '0;
                    end else begin
                        cnt_nx   = CW'(1);
                        state_nx = (HDR_LEN == 1) ? ST_PAY : ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                if (in_valid) begin
                    if (in_last) begin
                        len_err_set = 1'b1;
                        cnt_nx      = '0;
                        state_nx    = ST_IDLE;
                    end else begin
                        cnt_nx = cnt + CW'(1);
                        if (cnt == HDR_LAST) state_nx = ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                if (in_valid) begin
                    cmd_shift = 1'b1;
                    wr_en     = !no_room && (cnt < STRM_END);
                    wr_last   = (cnt == STRM_LAST);
                    if (cnt != '1) cnt_nx = cnt + CW'(1);
                    if (in_last) begin
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                        if (cnt == STRM_LAST) begin
                            if (no_room) begin
                                ovf_set  = 1'b1;
                                rollback = 1'b1;
                            end else begin
                                commit = 1'b1;
                            end
                        end else if (cnt == CMD_LAST) begin
                            cmd_fire = 1'b1;
                            rollback = 1'b1;
                        end else begin
                            len_err_set = 1'b1;
                            rollback    = 1'b1;
                        end
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/udp_sort_fifo.sv
module udp_sort_fifo
    import udp_sort_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  strm_entry_t                wr_entry,
    input  logic                       commit,
    input  logic                       rollback,
    input  logic                       rd_ready,
    output logic                       rd_valid,
    output strm_entry_t                rd_entry,
    output logic [$clog2(DEPTH):0]     used
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    strm_entry_t   mem [DEPTH];
    logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
    logic [PW-1:0] wr_next;

    assign wr_next  = wr_ptr + PW'(wr_en);
    assign rd_valid = (rd_ptr != cm_ptr);
    assign rd_entry = mem[rd_ptr[AW-1:0]];
    assign used     = wr_ptr - rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (rollback) begin
                wr_ptr <= cm_ptr;
            end else begin
                wr_ptr <= wr_next;
                if (commit) cm_ptr <= wr_next;
            end
            if (rd_valid && rd_ready) rd_ptr <= rd_ptr + PW'(1);
        end
    end
endmodule

// File: rtl/udp_sort_cmd.sv
module udp_sort_cmd #(
    parameter int CMD_PAY = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   shift,
    input  logic                   fire,
    input  logic [7:0]             in_data,
    output logic                   cmd_valid,
    output logic [CMD_PAY*8-1:0]   cmd_word
);
    localparam int CMD_W = CMD_PAY * 8;

    logic [CMD_W-1:0] sh;
    logic [CMD_W+7:0] cat;

    assign cat = {sh, in_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= fire;
            if (shift) sh       <= cat[CMD_W-1:0];
            if (fire)  cmd_word <= cat[CMD_W-1:0];
        end
    end
endmodule

// File: rtl/udp_rx_sorter.sv
module udp_rx_sorter
    import udp_sort_pkg::*;
#(
    parameter int HDR_LEN    = 42,
    parameter int CMD_LEN    = 49,
    parameter int STRM_LEN   = 557,
    parameter int FIFO_DEPTH = 1024
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [7:0]                        in_data,
    input  logic                              in_last,
    output logic                              cmd_valid,
    output logic [8*(CMD_LEN-HDR_LEN)-1:0]    cmd_word,
    output logic                              strm_valid,
    input  logic                              strm_ready,
    output logic [7:0]                        strm_data,
    output logic                              strm_last,
    output logic                              len_err,
    output logic                              ovf_err
);
    localparam int CMD_PAY  = CMD_LEN - HDR_LEN;
    localparam int STRM_PAY = STRM_LEN - HDR_LEN;
    localparam int AW       = $clog2(FIFO_DEPTH);

    logic wr_en, wr_last, commit, rollback, cmd_shift, cmd_fire;
    logic len_err_set, ovf_set, room;
    logic [AW:0] used;
    strm_entry_t wr_entry, rd_entry;

    assign room     = ({1'b0, used} + (AW+2)'(STRM_PAY)) <= (AW+2)'(FIFO_DEPTH);
    assign wr_entry = '{last: wr_last, data: in_data};

    udp_sort_ctrl #(
        .HDR_LEN (HDR_LEN),
        .CMD_LEN (CMD_LEN),
        .STRM_LEN(STRM_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .room       (room),
        .wr_en      (wr_en),
        .wr_last    (wr_last),
        .commit     (commit),
        .rollback   (rollback),
        .cmd_shift  (cmd_shift),
        .cmd_fire   (cmd_fire),
        .len_err_set(len_err_set),
        .ovf_set    (ovf_set)
    );

    udp_sort_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_entry(wr_entry),
        .commit  (commit),
        .rollback(rollback),
        .rd_ready(strm_ready),
        .rd_valid(strm_valid),
        .rd_entry(rd_entry),
        .used    (used)
    );

    udp_sort_cmd #(.CMD_PAY(CMD_PAY)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (cmd_shift),
        .fire     (cmd_fire),
        .in_data  (in_data),
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word)
    );

    assign strm_data = rd_entry.data;
    assign strm_last = rd_entry.last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_err <= 1'b0;
            ovf_err <= 1'b0;
        end else begin
            len_err <= len_err | len_err_set;
            ovf_err <= ovf_err | ovf_set;
        end
    end
endmodule

// File: rtl/udp_sort_chk.sv
module udp_sort_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_last,
    input logic       cmd_valid,
    input logic       strm_valid,
    input logic       strm_ready,
    input logic [7:0] strm_data,
    input logic       strm_last,
    input logic       len_err,
    input logic       ovf_err
);
    a_r2_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r2_cmd_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(in_valid && in_last));

    a_r4_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strm_valid && !strm_ready) |=> (strm_valid && $stable(strm_data) && $stable(strm_last)));

    a_r5_len_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

bind udp_rx_sorter udp_sort_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .cmd_valid (cmd_valid),
    .strm_valid(strm_valid),
    .strm_ready(strm_ready),
    .strm_data (strm_data),
    .strm_last (strm_last),
    .len_err   (len_err),
    .ovf_err   (ovf_err)
);

// File: tb/udp_rx_sorter_test.sv
module udp_rx_sorter_test;
    localparam int HDR  = 6;
    localparam int CLEN = 9;
    localparam int SLEN = 14;
    localparam int SPAY = SLEN - HDR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        cmd_valid;
    logic [23:0] cmd_word;
    logic        strm_valid;
    logic        strm_ready = 1'b1;
    logic [7:0]  strm_data;
    logic        strm_last;
    logic        len_err, ovf_err;

    logic        stall_mode = 1'b0;
    logic        ready_req  = 1'b1;

    int checks = 0, errors = 0;
    int mchecks = 0, merrors = 0;
    int rx_n = 0, cmd_n = 0, cyc = 0;
    logic [7:0]  rx_data [64];
    logic        rx_last [64];
    logic [23:0] cmd_seen = '0;
    logic        hold_pend = 1'b0;
    logic [7:0]  hold_d = '0;
    logic        hold_l = 1'b0;

    always #10 clk = ~clk;

    udp_rx_sorter #(.HDR_LEN(HDR), .CMD_LEN(CLEN), .STRM_LEN(SLEN), .FIFO_DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .strm_valid(strm_valid),
        .strm_ready(strm_ready), .strm_data(strm_data), .strm_last(strm_last),
        .len_err(len_err), .ovf_err(ovf_err)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        strm_ready = stall_mode ? ((cyc % 3) != 0) : ready_req;
    end

    // output monitor, mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                mchecks = mchecks + 1;
                if (!(strm_valid && strm_data == hold_d && strm_last == hold_l)) begin
                    merrors = merrors + 1;
                    $display("FAIL R4 hold: actual v=%0b d=%h l=%0b expected v=1 d=%h l=%0b",
                             strm_valid, strm_data, strm_last, hold_d, hold_l);
                end
            end
            hold_pend = strm_valid && !strm_ready;
            hold_d    = strm_data;
            hold_l    = strm_last;
            if (strm_valid && strm_ready && rx_n < 64) begin
                rx_data[rx_n] = strm_data;
                rx_last[rx_n] = strm_last;
                rx_n = rx_n + 1;
            end
            if (cmd_valid) begin
                cmd_n    = cmd_n + 1;
                cmd_seen = cmd_word;
            end
        end else begin
            hold_pend = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;
    endtask

    task automatic send_frame(input int len, input logic [7:0] base, input int gap, output bit early);
        early = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b1;
            in_data  = base + 8'(i);
            in_last  = (i == len - 1);
            @(negedge clk);
            if (strm_valid) early = 1'b1;
            if (i < len - 1) begin
                repeat (gap) begin
                    @(posedge clk); #2;
                    in_valid = 1'b0;
                end
            end
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic expect_frame(input string tag, input int start, input logic [7:0] base);
        logic [7:0] ad, ed;
        logic       al, el;
        bit         bad;
        bad = 1'b0; ad = '0; ed = '0; al = 1'b0; el = 1'b0;
        for (int k = 0; k < SPAY; k++) begin
            if (!bad && (rx_data[start+k] !== base + 8'(HDR + k) || rx_last[start+k] !== (k == SPAY - 1))) begin
                bad = 1'b1;
                ad = rx_data[start+k]; ed = base + 8'(HDR + k);
                al = rx_last[start+k]; el = (k == SPAY - 1);
            end
        end
        check(tag, {23'd0, al, ad}, bad ? {23'd0, el, ed} : {23'd0, al, ad});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R7 cmd_valid after reset", 32'(cmd_valid), 32'd0);
        check("R7 strm_valid after reset", 32'(strm_valid), 32'd0);
        check("R7 flags after reset", {30'd0, len_err, ovf_err}, 32'd0);
    endtask

    task automatic t_cmd();
        bit e;
        int r0;
        r0 = rx_n;
        send_frame(CLEN, 8'h10, 0, e);
        @(negedge clk);
        check("R2 cmd_valid after last byte", 32'(cmd_valid), 32'd1);
        check("R2 R1 cmd_word payload order", 32'(cmd_word), 32'h00161718);
        @(negedge clk);
        check("R2 cmd_valid single pulse", 32'(cmd_valid), 32'd0);
        repeat (5) @(negedge clk);
        check("R8 no stream bytes from command", 32'(rx_n - r0), 32'd0);
    endtask

    task automatic t_stream();
        bit e;
        int r0;
        r0 = rx_n;
        send_frame(SLEN, 8'h40, 0, e);
        check("R3 nothing before end of frame", 32'(e), 32'd0);
        repeat (20) @(negedge clk);
        check("R3 stream byte count", 32'(rx_n - r0), 32'(SPAY));
        expect_frame("R1 R3 stream payload", r0, 8'h40);
    endtask

    task automatic t_badlen();
        bit e;
        int r0, c0;
        check("R5 len_err clear before", 32'(len_err), 32'd0);
        r0 = rx_n; c0 = cmd_n;
        send_frame(3, 8'h60, 0, e);
        repeat (4) @(negedge clk);
        check("R5 frame ending in header", 32'(len_err), 32'd1);
        do_reset();
        send_frame(11, 8'h60, 0, e);
        repeat (20) @(negedge clk);
        check("R5 mid length sets len_err", 32'(len_err), 32'd1);
        send_frame(20, 8'h68, 0, e);
        repeat (20) @(negedge clk);
        check("R5 no output from bad frames", 32'((rx_n - r0) + (cmd_n - c0)), 32'd0);
        send_frame(CLEN, 8'h70, 0, e);
        repeat (3) @(negedge clk);
        check("R5 good cmd after bad frames", 32'(cmd_seen), 32'h00767778);
        check("R5 len_err sticky", 32'(len_err), 32'd1);
    endtask

    task automatic t_stall();
        bit e;
        int r0;
        r0 = rx_n;
        stall_mode = 1'b1;
        send_frame(SLEN, 8'h80, 0, e);
        send_frame(SLEN, 8'hA0, 0, e);
        repeat (60) @(negedge clk);
        stall_mode = 1'b0;
        repeat (10) @(negedge clk);
        check("R4 stalled byte count", 32'(rx_n - r0), 32'(2 * SPAY));
        expect_frame("R4 first stalled frame", r0, 8'h80);
        expect_frame("R4 second stalled frame", r0 + SPAY, 8'hA0);
    endtask

    task automatic t_ovf();
        bit e;
        int r0, c0;
        check("R6 ovf_err clear before", 32'(ovf_err), 32'd0);
        ready_req = 1'b0;
        repeat (2) @(posedge clk);
        r0 = rx_n; c0 = cmd_n;
        send_frame(SLEN, 8'h20, 0, e);
        send_frame(SLEN, 8'h30, 0, e);
        send_frame(SLEN, 8'hC0, 0, e);
        repeat (3) @(negedge clk);
        check("R6 overflow flag", 32'(ovf_err), 32'd1);
        send_frame(CLEN, 8'h50, 0, e);
        repeat (3) @(negedge clk);
        check("R6 command delivered while full", {8'(cmd_n - c0), cmd_seen}, {8'd1, 24'h565758});
        ready_req = 1'b1;
        repeat (40) @(negedge clk);
        check("R6 only fitting frames delivered", 32'(rx_n - r0), 32'(2 * SPAY));
        expect_frame("R6 first kept frame", r0, 8'h20);
        expect_frame("R6 second kept frame", r0 + SPAY, 8'h30);
        check("R6 ovf_err sticky", 32'(ovf_err), 32'd1);
    endtask

    task automatic t_gap();
        bit e;
        int r0;
        r0 = rx_n;
        send_frame(CLEN, 8'h90, 2, e);
        repeat (3) @(negedge clk);
        check("R9 command with idle gaps", 32'(cmd_seen), 32'h00969798);
        send_frame(SLEN, 8'hB0, 3, e);
        repeat (20) @(negedge clk);
        check("R9 stream count with gaps", 32'(rx_n - r0), 32'(SPAY));
        expect_frame("R9 stream payload with gaps", r0, 8'hB0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_cmd();
        t_stream();
        t_badlen();
        do_reset();
        t_stall();
        t_ovf();
        t_gap();
        $display("Simulation finished: %0d checks, %0d errors", checks + mchecks, errors + merrors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog (all R): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + mchecks + 1, errors + merrors + 1);
        $finish;
    end
endmodule